// File: doc/BRIEF.md
# Reset Supervisor with Start-up Delay

This block decides when the core of a small 8-bit controller is held in reset and when it may run. It watches four sources: a power-on event, an external reset pin, a watchdog expiry pulse, and the core's entry into and wake-up from the low-power HALT state. For each reset it picks the cause, decides whether the oscillator needs time to settle, holds the core in reset for that long, and then releases it. A reset always restarts the program counter at address 0, so `core_rst` is the program-counter clear for the whole core.

The block keeps two status bits that software reads after a restart: a time-out bit (`to_flag`) and a power-down bit (`pdf_flag`). Each reset or wake condition leaves them in its own pattern, so the firmware can tell why it restarted. The block also classifies each reset as warm or cold. Other register files use `warm_rst` to keep their contents and `cold_rst` to load their reset values.

The settling delay is `DLY_CYCLES` clock cycles (default 1024). The `por_evt` input also serves as the block's synchronous active-high reset. After a power-on event, the first edge with `por_evt` low starts the delay.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_evt` is high, `core_rst` and `cold_rst` are 1 and both flags read 0. After `por_evt` falls, `core_run` stays 0 for exactly `DLY_CYCLES` further sampled cycles and then becomes 1.
- R2: With the core running or in reset, `pin_rst` holds `core_rst` and `cold_rst` high while the pin is high. Both flags keep their values. No delay is added: `core_run` returns on the first edge after the pin falls.
- R3: A one-cycle `wdt_tmo` pulse with the core not in HALT gives one cycle of cold reset with no delay. It sets `to_flag` to 1 and leaves `pdf_flag` unchanged.
- R4: `pin_rst` during HALT gives a cold reset with `to_flag`=0 and `pdf_flag`=1. After the pin falls, `core_run` stays 0 for `DLY_CYCLES` samples.
- R5: `wdt_tmo` during HALT gives a warm reset (`warm_rst`=1, `cold_rst`=0), sets both flags to 1, and adds the delay of `DLY_CYCLES` samples.
- R6: `wake_evt` during HALT resumes the core without any reset. `core_rst` stays 0 and the flags are unchanged. `core_run` returns `DLY_CYCLES` cycles after the wake edge.
- R7: When several causes arrive in the same cycle, power-on wins over the pin, and the pin wins over the watchdog. Only the winner sets the flags and the warm/cold class.
- R8: A reset cause that arrives while the delay is counting restarts the delay in full, and the cause is judged as one outside HALT.
- R9: `halt_enter` is obeyed only while the core runs: it stops the core on the next edge. `halt_enter` during reset or delay, and `wake_evt` outside HALT, have no effect.
- R10: `core_run` is 0 in every cycle in which `core_rst` is 1, and `warm_rst` is never 1 unless both flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_evt | input | 1 | Power-on event, active high; also the block's synchronous reset |
| pin_rst | input | 1 | External reset pin level, active high |
| wdt_tmo | input | 1 | Watchdog expiry pulse |
| halt_enter | input | 1 | Core executed HALT (one-cycle pulse) |
| wake_evt | input | 1 | Non-reset wake-up request from HALT |
| core_rst | output | 1 | Core held in reset; program counter forced to 0 |
| cold_rst | output | 1 | Current reset loads reset values |
| warm_rst | output | 1 | Current reset keeps register contents |
| core_run | output | 1 | Core is executing instructions |
| to_flag | output | 1 | Time-out status bit |
| pdf_flag | output | 1 | Power-down status bit |

## Verification
The hardest condition to reach is a reset that lands partway through a running delay. To get there, the core first has to be put into HALT and woken by a watchdog, and then a second cause has to arrive at a chosen cycle inside the 1024-cycle window. Without a directed sequence this almost never happens. The stimulus therefore times a second watchdog pulse and a `halt_enter` pulse inside an active delay, and then counts the stalled cycles that remain. Random rounds mix HALT entry with simultaneous cause combinations, and a bench model predicts the flags and the delay length for each round.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_HALT,
        ST_RST,
        ST_DLY
    } sup_state_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_POR,
        SRC_PIN,
        SRC_WDT,
        SRC_WAKE
    } src_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_COLD,
        KIND_WARM
    } rst_kind_e;

    typedef struct packed {
        src_e src;
        logic in_halt;
    } cause_t;

    typedef struct packed {
        logic to;
        logic pdf;
    } flags_t;

    function automatic logic is_reset(src_e s);
        return (s == SRC_POR) || (s == SRC_PIN) || (s == SRC_WDT);
    endfunction

    function automatic rst_kind_e kind_of(cause_t c);
        if (c.src == SRC_WDT && c.in_halt)
            return KIND_WARM;
        return KIND_COLD;
    endfunction

    function automatic flags_t next_flags(cause_t c, flags_t cur);
        flags_t f;
        f = cur;
        case (c.src)
            SRC_POR: f = '{to: 1'b0, pdf: 1'b0};
            SRC_PIN: if (c.in_halt) f = '{to: 1'b0, pdf: 1'b1};
            SRC_WDT: begin
                f.to = 1'b1;
                if (c.in_halt) f.pdf = 1'b1;
            end
            default: f = cur;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/rst_cause_arb.sv
module rst_cause_arb
    import rst_sup_pkg::*;
(
    input  logic       por_i,
    input  logic       pin_i,
    input  logic       wdt_i,
    input  logic       wake_i,
    input  sup_state_e state_i,
    output cause_t     cause_o
);

    logic halted;

    assign halted = (state_i == ST_HALT);

    always_comb begin
        cause_o.in_halt = halted;
        if (por_i)
            cause_o.src = SRC_POR;
        else if (pin_i)
            cause_o.src = SRC_PIN;
        else if (wdt_i)
            cause_o.src = SRC_WDT;
        else if (wake_i && halted)
            cause_o.src = SRC_WAKE;
        else
            cause_o.src = SRC_NONE;
    end

endmodule

// File: rtl/rst_startup_cnt.sv
module rst_startup_cnt #(
    parameter int CYCLES = 1024
) (
    input  logic clk,
    input  logic clr_i,
    output logic done_o
);

    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr_i)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + CW'(1);
    end

    assign done_o = !clr_i && (cnt == LAST);

    // R1 / R8: every counting cycle advances by exactly one until the end
    a_r1_count_step: assert property (@(posedge clk) disable iff (clr_i)
        !done_o |=> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/rst_status_flags.sv
module rst_status_flags
    import rst_sup_pkg::*;
(
    input  logic   clk,
    input  cause_t cause_i,
    output flags_t flags_o
);

    flags_t flags_q;

    always_ff @(posedge clk) begin
        if (is_reset(cause_i.src))
            flags_q <= next_flags(cause_i, flags_q);
    end

    assign flags_o = flags_q;

    a_r1_por_clears: assert property (@(posedge clk)
        (cause_i.src == SRC_POR) |=> (!flags_q.to && !flags_q.pdf));

    a_r2_pin_run_keeps: assert property (@(posedge clk)
        (cause_i.src == SRC_PIN && !cause_i.in_halt) |=> (flags_q == $past(flags_q)));

    a_r3_wdt_run_sets_to: assert property (@(posedge clk)
        (cause_i.src == SRC_WDT && !cause_i.in_halt) |=>
            (flags_q.to && flags_q.pdf == $past(flags_q.pdf)));

    a_r4_pin_halt_pattern: assert property (@(posedge clk)
        (cause_i.src == SRC_PIN && cause_i.in_halt) |=> (!flags_q.to && flags_q.pdf));

    a_r5_wdt_halt_pattern: assert property (@(posedge clk)
        (cause_i.src == SRC_WDT && cause_i.in_halt) |=> (flags_q.to && flags_q.pdf));

    a_r6_wake_keeps: assert property (@(posedge clk)
        (cause_i.src == SRC_WAKE) |=> (flags_q == $past(flags_q)));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rst_sup_pkg::*;
#(
    parameter int DLY_CYCLES = 1024
) (
    input  logic clk,
    input  logic por_evt,
    input  logic pin_rst,
    input  logic wdt_tmo,
    input  logic halt_enter,
    input  logic wake_evt,
    output logic core_rst,
    output logic cold_rst,
    output logic warm_rst,
    output logic core_run,
    output logic to_flag,
    output logic pdf_flag
);

    sup_state_e state;
    rst_kind_e  kind;
    logic       need_dly;
    logic       need_dly_n;
    cause_t     cause;
    flags_t     flags;
    logic       dly_done;

    rst_cause_arb u_arb (
        .por_i   (por_evt),
        .pin_i   (pin_rst),
        .wdt_i   (wdt_tmo),
        .wake_i  (wake_evt),
        .state_i (state),
        .cause_o (cause)
    );

    rst_startup_cnt #(.CYCLES(DLY_CYCLES)) u_cnt (
        .clk    (clk),
        .clr_i  (state != ST_DLY),
        .done_o (dly_done)
    );

    rst_status_flags u_flags (
        .clk     (clk),
        .cause_i (cause),
        .flags_o (flags)
    );

    // Delay needed when waking from HALT, after power-on, or when a delay
    // already in progress is interrupted (oscillator may still be settling).
    assign need_dly_n = cause.in_halt
                      || (cause.src == SRC_POR)
                      || (state == ST_DLY)
                      || (state == ST_RST && need_dly);

    always_ff @(posedge clk) begin
        if (is_reset(cause.src)) begin
            state    <= ST_RST;
            need_dly <= need_dly_n;
            kind     <= kind_of(cause);
        end else begin
            case (state)
                ST_RUN:  if (halt_enter) state <= ST_HALT;
                ST_HALT: if (cause.src == SRC_WAKE) begin
                    state <= ST_DLY;
                    kind  <= KIND_NONE;
                end
                ST_RST:  state <= need_dly ? ST_DLY : ST_RUN;
                ST_DLY:  if (dly_done) state <= ST_RUN;
                default: state <= ST_RST;
            endcase
        end
    end

    assign core_rst = (state == ST_RST) || (state == ST_DLY && kind != KIND_NONE);
    assign cold_rst = core_rst && (kind == KIND_COLD);
    assign warm_rst = core_rst && (kind == KIND_WARM);
    assign core_run = (state == ST_RUN);
    assign to_flag  = flags.to;
    assign pdf_flag = flags.pdf;

    a_r10_rst_stops_core: assert property (@(posedge clk) disable iff (por_evt)
        core_rst |-> !core_run);

    a_r10_warm_flags: assert property (@(posedge clk) disable iff (por_evt)
        warm_rst |-> (to_flag && pdf_flag));

    a_r8_delay_ends_run: assert property (@(posedge clk) disable iff (por_evt)
        (state == ST_DLY && dly_done && cause.src == SRC_NONE) |=> core_run);

    a_r2_no_delay_release: assert property (@(posedge clk) disable iff (por_evt)
        (state == ST_RST && !need_dly && cause.src == SRC_NONE) |=> core_run);

    a_r9_halt_only_from_run: assert property (@(posedge clk) disable iff (por_evt)
        (state == ST_RST || state == ST_DLY) |=> (state != ST_HALT));

    a_r7_pin_over_wdt: assert property (@(posedge clk) disable iff (por_evt)
        (pin_rst && wdt_tmo) |=> (cold_rst && !warm_rst));

endmodule

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 1024;
    localparam int LIMIT      = 190000;

    logic clk = 1'b0;
    logic por_evt = 1'b1, pin_rst = 1'b0, wdt_tmo = 1'b0;
    logic halt_enter = 1'b0, wake_evt = 1'b0;
    logic core_rst, cold_rst, warm_rst, core_run, to_flag, pdf_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    bit m_to, m_pdf, m_halt;

    rst_supervisor #(.DLY_CYCLES(N)) i_rst_supervisor (
        .clk        (clk),
        .por_evt    (por_evt),
        .pin_rst    (pin_rst),
        .wdt_tmo    (wdt_tmo),
        .halt_enter (halt_enter),
        .wake_evt   (wake_evt),
        .core_rst   (core_rst),
        .cold_rst   (cold_rst),
        .warm_rst   (warm_rst),
        .core_run   (core_run),
        .to_flag    (to_flag),
        .pdf_flag   (pdf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // cause code: 0 none, 1 power-on, 2 pin, 3 watchdog, 4 wake
    function automatic int win(bit p, bit n, bit w, bit wk, bit h);
        if (p) return 1;
        if (n) return 2;
        if (w) return 3;
        if (wk && h) return 4;
        return 0;
    endfunction

    function automatic bit [1:0] exp_flags(int src, bit h, bit t, bit d);
        case (src)
            1: return 2'b00;
            2: return h ? 2'b01 : {t, d};
            3: return {1'b1, h ? 1'b1 : d};
            default: return {t, d};
        endcase
    endfunction

    // Apply a cause set for 'hold' cycles, check at the last sample, then clear.
    task automatic apply(bit p, bit n, bit w, bit wk, int hold, string req,
                         output int exp_wait);
        int src;
        bit [1:0] f;
        src = win(p, n, w, wk, m_halt);
        f = exp_flags(src, m_halt, m_to, m_pdf);
        @(negedge clk);
        por_evt = p; pin_rst = n; wdt_tmo = w; wake_evt = wk;
        repeat (hold) @(negedge clk);
        chk({req, " core_rst"}, core_rst, (src >= 1 && src <= 3) ? 1 : 0);
        chk({req, " cold_rst"}, cold_rst, (src == 1 || src == 2 || (src == 3 && !m_halt)) ? 1 : 0);
        chk({req, " warm_rst"}, warm_rst, (src == 3 && m_halt) ? 1 : 0);
        chk({req, " to_flag"}, to_flag, f[1]);
        chk({req, " pdf_flag"}, pdf_flag, f[0]);
        case (src)
            1: exp_wait = N;
            2, 3: exp_wait = m_halt ? N : 0;
            4: exp_wait = N - 1;
            default: exp_wait = -1;
        endcase
        m_to = f[1]; m_pdf = f[0];
        if (src != 0) m_halt = 0;
        por_evt = 0; pin_rst = 0; wdt_tmo = 0; wake_evt = 0;
    endtask

    task automatic settle(string req, int exp_wait);
        int n = 0;
        forever begin
            @(negedge clk);
            if (core_run) break;
            n++;
            if (n > 3 * N) break;
        end
        chk({req, " stall cycles"}, n, exp_wait);
    endtask

    task automatic go_halt();
        @(negedge clk);
        halt_enter = 1;
        @(negedge clk);
        halt_enter = 0;
        chk("R9 halt entered core_run", core_run, 0);
        chk("R9 halt entered core_rst", core_rst, 0);
        m_halt = 1;
    endtask

    initial begin
        int w;
        void'($urandom(32'd20240611));
        m_halt = 0;

        // R1: power-on from time zero
        repeat (3) @(negedge clk);
        chk("R1 por core_rst", core_rst, 1);
        chk("R1 por cold_rst", cold_rst, 1);
        chk("R1 por to_flag", to_flag, 0);
        chk("R1 por pdf_flag", pdf_flag, 0);
        por_evt = 0;
        settle("R1 por", N);
        m_to = 0; m_pdf = 0;

        // R3 watchdog in run, then R2 pin in run keeps flags
        apply(0, 0, 1, 0, 1, "R3 wdt run", w); settle("R3 wdt run", w);
        apply(0, 1, 0, 0, 3, "R2 pin run", w); settle("R2 pin run", w);
        // R4 pin in halt, R5 wdt in halt, R6 wake
        go_halt(); apply(0, 1, 0, 0, 2, "R4 pin halt", w); settle("R4 pin halt", w);
        go_halt(); apply(0, 0, 1, 0, 1, "R5 wdt halt", w); settle("R5 wdt halt", w);
        go_halt(); apply(0, 0, 0, 1, 1, "R6 wake", w); settle("R6 wake", w);
        // R7 priorities
        apply(0, 1, 1, 0, 1, "R7 pin over wdt", w); settle("R7 pin over wdt", w);
        go_halt(); apply(0, 1, 1, 0, 1, "R7 pin over wdt halt", w); settle("R7 halt", w);
        apply(1, 1, 1, 0, 1, "R7 por over all", w); settle("R7 por", w);

        // R9: wake outside HALT is ignored
        @(negedge clk); wake_evt = 1;
        @(negedge clk); wake_evt = 0;
        chk("R9 wake in run core_run", core_run, 1);
        chk("R9 wake in run core_rst", core_rst, 0);

        // R8: watchdog during a warm delay restarts it as cold
        go_halt(); apply(0, 0, 1, 0, 1, "R5 warm start", w);
        repeat (20) @(negedge clk);
        chk("R8 mid delay core_run", core_run, 0);
        m_halt = 0;
        apply(0, 0, 1, 0, 1, "R8 wdt in delay", w);
        settle("R8 restart", N);

        // R9: halt_enter during delay is ignored
        apply(1, 0, 0, 0, 1, "R9 por", w);
        halt_enter = 1;
        @(negedge clk); halt_enter = 0;
        settle("R9 halt in delay", N - 1);
        @(negedge clk);
        chk("R9 no halt after delay", core_run, 1);

        // random rounds
        for (int i = 0; i < 40; i++) begin
            int k;
            if ($urandom % 2) go_halt();
            k = $urandom % 6;
            case (k)
                0: apply(1, 0, 0, 0, 1, "R1 rnd", w);
                1: apply(0, 1, 0, 0, 1 + ($urandom % 3), "R2 R4 rnd", w);
                2: apply(0, 0, 1, 0, 1, "R3 R5 rnd", w);
                3: apply(0, 1, 1, 0, 1, "R7 rnd", w);
                4: apply(0, 0, 1, 1, 1, "R7 wdt wake rnd", w);
                default: apply(0, 0, 0, 1, 1, "R6 R9 rnd", w);
            endcase
            if (w >= 0) settle("R1 R6 rnd", w);
            else chk("R9 rnd ignored wake", core_run, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule